// File: doc/BRIEF.md
# Multithreaded Warp Issue Scheduler

The scheduler keeps a pool of up to 32 resident warps for one multiprocessor. Each warp holds 32 threads, and all of them share one instruction stream. For every warp the block keeps a program counter, a program number and a 32-bit per-thread enable mask. Warps resident at the same time may run different programs. In each issue slot the scheduler picks one warp that is ready and sends its next instruction to a group of 8 scalar lanes. Because there are 8 lanes and 32 threads, the warp is streamed over 4 consecutive beats. On each beat the lanes see the matching byte of the mask, so threads that are switched off by divergence stay idle.

Thread blocks enter through an admission port. A block asks for a number of whole warps. It is taken only if a block slot is free, enough warp slots are free, and the resident thread total stays within its limit. Warps leave one at a time through a retire port. Divergence is not computed here. The control flow logic outside the block writes a new mask for a warp, and an external ready vector marks the warps whose operands are available.

Top module: `simt_warp_sched`

## Requirements
- R1: Synchronous active-high reset empties the pool and clears the issue and lane outputs (`iss_valid`, `lane_valid` low, `lane_en` zero). After reset, admission is possible.
- R2: `adm_accept` is combinational and goes high with `adm_valid` only if all of the following hold: 1 ≤ `adm_warps` ≤ 16, a block slot is free, enough warp slots are free, and the thread total plus 32·`adm_warps` is at most 768. Accepted warps take the lowest-numbered free warp IDs in ascending order. They start with an all-ones mask and with `adm_pc` and `adm_prog`.
- R3: At most 8 blocks are resident. A ninth block is refused.
- R4: A block that would bring the resident thread total above 768 is refused. A block that brings it to exactly 768 is accepted.
- R5: Retiring a resident warp removes it for good. Retiring the last warp of a block frees the block slot and its threads at the same clock edge, so an admission in the next cycle can use them.
- R6: A warp is issued only if it is resident, its `warp_ready` bit is high, its mask is nonzero, and it does not occupy the lanes.
- R7: Among eligible warps, the grant goes to the first one at or after a rotating pointer. The pointer then moves to the granted ID plus one, wrapping from 31 to 0.
- R8: An issue gives a one-cycle `iss_valid` pulse with warp ID, program number, program counter and mask. The program counter of that warp is incremented by one for its next issue.
- R9: Lane beats start in the cycle of `iss_valid`. `lane_valid` stays high for 4 cycles with `lane_beat` counting 0 to 3, and `lane_en` carries mask bits [8b+7:8b] on beat b. `lane_en` is zero while `lane_valid` is low.
- R10: The next issue can come at the earliest in the cycle after beat 3. A warp is not eligible during its own last beat. So a single eligible warp issues every 5 cycles, and two eligible warps alternate every 4 cycles.
- R11: A mask write replaces the warp's mask. A warp whose mask is all zeros is skipped until it gets a nonzero mask.
- R12: Each warp keeps its own program number, and each issue reports the number of the warp that was granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adm_valid | input | 1 | Block admission request |
| adm_warps | input | 5 | Number of warps in the requested block |
| adm_prog | input | 4 | Program number for the block's warps |
| adm_pc | input | 16 | Start program counter |
| adm_accept | output | 1 | Request accepted this cycle |
| ret_valid | input | 1 | Retire a warp |
| ret_warp | input | 5 | Warp to retire |
| mask_wr | input | 1 | Write a new active mask |
| mask_warp | input | 5 | Warp whose mask is written |
| mask_val | input | 32 | New per-thread mask |
| warp_ready | input | 32 | Per-warp ready flags |
| iss_valid | output | 1 | Issue strobe |
| iss_warp | output | 5 | Issued warp ID |
| iss_prog | output | 4 | Issued program number |
| iss_pc | output | 16 | Issued program counter |
| iss_mask | output | 32 | Issued active mask |
| lane_valid | output | 1 | Lanes busy with a beat |
| lane_beat | output | 2 | Current beat, 0 to 3 |
| lane_en | output | 8 | Per-lane enable for the beat |

## Verification
The issue logic is tested with three ready patterns. A single ready warp exposes the 5-cycle cadence and the program counter increment. Two ready warps show the rotating pointer and the 4-cycle alternation. A warp whose mask is zero while another warp is ready shows that empty masks are skipped. A sparse mask with a different byte in each position shows that each beat selects the correct slice. On the admission side, the tests fill the block slots and the thread budget to the exact edge and one step past it. They also retire the last warp of a block to show that its resources come back in the next cycle and that the freed warp ID is reused.

// File: rtl/simt_sched_pkg.sv
package simt_sched_pkg;
    localparam int WARP_THREADS = 32;
    typedef enum logic {LANE_IDLE, LANE_RUN} lane_state_e;
endpackage

// File: rtl/simt_rr_pick.sv
module simt_rr_pick #(
    parameter int N = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] grant
);
    always_comb begin
        int idx;
        found = 1'b0;
        grant = '0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!found && elig[idx]) begin
                found = 1'b1;
                grant = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/simt_lane_seq.sv
module simt_lane_seq
    import simt_sched_pkg::*;
#(
    parameter int THREADS = 32,
    parameter int LANES   = 8,
    parameter int WID_W   = 5,
    localparam int BEATS  = THREADS / LANES,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WID_W-1:0]   start_warp,
    input  logic [THREADS-1:0] start_mask,
    output logic               busy,
    output logic               last,
    output logic [BEAT_W-1:0]  beat,
    output logic [WID_W-1:0]   cur_warp,
    output logic [LANES-1:0]   lane_en
);
    typedef struct packed {
        lane_state_e        st;
        logic [BEAT_W-1:0]  beat;
        logic [WID_W-1:0]   warp;
        logic [THREADS-1:0] mask;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (start) begin
            seq_d.st   = LANE_RUN;
            seq_d.beat = '0;
            seq_d.warp = start_warp;
            seq_d.mask = start_mask;
        end else if (seq_q.st == LANE_RUN) begin
            if (seq_q.beat == BEAT_W'(BEATS - 1)) begin
                seq_d.st   = LANE_IDLE;
                seq_d.beat = '0;
            end else begin
                seq_d.beat = seq_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign busy     = (seq_q.st == LANE_RUN);
    assign last     = busy && (seq_q.beat == BEAT_W'(BEATS - 1));
    assign beat     = seq_q.beat;
    assign cur_warp = seq_q.warp;
    assign lane_en  = busy ? seq_q.mask[seq_q.beat * LANES +: LANES] : '0;
endmodule

// File: rtl/simt_warp_sched.sv
module simt_warp_sched
    import simt_sched_pkg::*;
#(
    parameter int NUM_WARPS     = 32,
    parameter int LANES         = 8,
    parameter int MAX_BLOCKS    = 8,
    parameter int MAX_THREADS   = 768,
    parameter int BLK_WARPS_MAX = 16,
    parameter int PC_W          = 16,
    parameter int PROG_W        = 4,
    localparam int WT     = WARP_THREADS,
    localparam int WID_W  = $clog2(NUM_WARPS),
    localparam int BID_W  = $clog2(MAX_BLOCKS),
    localparam int CNT_W  = $clog2(BLK_WARPS_MAX + 1),
    localparam int THR_W  = $clog2(MAX_THREADS + 1),
    localparam int BEATS  = WT / LANES,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adm_valid,
    input  logic [CNT_W-1:0]     adm_warps,
    input  logic [PROG_W-1:0]    adm_prog,
    input  logic [PC_W-1:0]      adm_pc,
    output logic                 adm_accept,
    input  logic                 ret_valid,
    input  logic [WID_W-1:0]     ret_warp,
    input  logic                 mask_wr,
    input  logic [WID_W-1:0]     mask_warp,
    input  logic [WT-1:0]        mask_val,
    input  logic [NUM_WARPS-1:0] warp_ready,
    output logic                 iss_valid,
    output logic [WID_W-1:0]     iss_warp,
    output logic [PROG_W-1:0]    iss_prog,
    output logic [PC_W-1:0]      iss_pc,
    output logic [WT-1:0]        iss_mask,
    output logic                 lane_valid,
    output logic [BEAT_W-1:0]    lane_beat,
    output logic [LANES-1:0]     lane_en
);
    typedef struct packed {
        logic [NUM_WARPS-1:0]               live;
        logic [NUM_WARPS-1:0][WT-1:0]       mask;
        logic [NUM_WARPS-1:0][PC_W-1:0]     pc;
        logic [NUM_WARPS-1:0][PROG_W-1:0]   prog;
        logic [NUM_WARPS-1:0][BID_W-1:0]    blk;
        logic [MAX_BLOCKS-1:0]              blk_used;
        logic [MAX_BLOCKS-1:0][CNT_W-1:0]   blk_cnt;
        logic [THR_W-1:0]                   threads;
        logic [WID_W-1:0]                   ptr;
        logic                               iss_v;
        logic [WID_W-1:0]                   iss_w;
        logic [PROG_W-1:0]                  iss_prog;
        logic [PC_W-1:0]                    iss_pc;
        logic [WT-1:0]                      iss_mask;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_WARPS-1:0] elig;
    logic                 pick_found;
    logic [WID_W-1:0]     pick_warp;
    logic                 fire;
    logic                 seq_busy, seq_last;
    logic [WID_W-1:0]     seq_warp;
    logic                 adm_ok;

    always_comb begin
        for (int i = 0; i < NUM_WARPS; i++) begin
            elig[i] = st_q.live[i] && warp_ready[i] && (|st_q.mask[i])
                      && !(seq_busy && (seq_warp == WID_W'(i)));
        end
    end

    simt_rr_pick #(.N(NUM_WARPS)) u_pick (
        .elig  (elig),
        .ptr   (st_q.ptr),
        .found (pick_found),
        .grant (pick_warp)
    );

    assign fire = pick_found && (!seq_busy || seq_last);

    simt_lane_seq #(.THREADS(WT), .LANES(LANES), .WID_W(WID_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (fire),
        .start_warp (pick_warp),
        .start_mask (st_q.mask[pick_warp]),
        .busy       (seq_busy),
        .last       (seq_last),
        .beat       (lane_beat),
        .cur_warp   (seq_warp),
        .lane_en    (lane_en)
    );

    always_comb begin
        int                nfree;
        int                need;
        int                taken;
        logic              blk_found;
        logic [BID_W-1:0]  fb;
        logic [BID_W-1:0]  rb;

        st_d       = st_q;
        st_d.iss_v = 1'b0;

        nfree = 0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            if (!st_q.live[i]) nfree++;
        end
        blk_found = 1'b0;
        fb        = '0;
        for (int b = 0; b < MAX_BLOCKS; b++) begin
            if (!blk_found && !st_q.blk_used[b]) begin
                blk_found = 1'b1;
                fb        = BID_W'(b);
            end
        end
        need   = int'(adm_warps) * WT;
        adm_ok = adm_valid && (adm_warps != '0)
                 && (int'(adm_warps) <= BLK_WARPS_MAX) && blk_found
                 && (nfree >= int'(adm_warps))
                 && (int'(st_q.threads) + need <= MAX_THREADS);

        if (fire) begin
            st_d.iss_v           = 1'b1;
            st_d.iss_w           = pick_warp;
            st_d.iss_prog        = st_q.prog[pick_warp];
            st_d.iss_pc          = st_q.pc[pick_warp];
            st_d.iss_mask        = st_q.mask[pick_warp];
            st_d.pc[pick_warp]   = st_q.pc[pick_warp] + 1'b1;
            st_d.ptr = (int'(pick_warp) == NUM_WARPS - 1) ? '0 : pick_warp + 1'b1;
        end

        if (mask_wr) st_d.mask[mask_warp] = mask_val;

        rb = st_q.blk[ret_warp];
        if (ret_valid && st_q.live[ret_warp]) begin
            st_d.live[ret_warp] = 1'b0;
            st_d.blk_cnt[rb]    = st_q.blk_cnt[rb] - 1'b1;
            if (st_q.blk_cnt[rb] == CNT_W'(1)) st_d.blk_used[rb] = 1'b0;
            st_d.threads = st_d.threads - THR_W'(WT);
        end

        taken = 0;
        if (adm_ok) begin
            st_d.blk_used[fb] = 1'b1;
            st_d.blk_cnt[fb]  = adm_warps;
            st_d.threads      = st_d.threads + THR_W'(need);
            for (int i = 0; i < NUM_WARPS; i++) begin
                if (!st_q.live[i] && taken < int'(adm_warps)) begin
                    st_d.live[i] = 1'b1;
                    st_d.mask[i] = '1;
                    st_d.pc[i]   = adm_pc;
                    st_d.prog[i] = adm_prog;
                    st_d.blk[i]  = fb;
                    taken++;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign adm_accept = adm_ok;
    assign iss_valid  = st_q.iss_v;
    assign iss_warp   = st_q.iss_w;
    assign iss_prog   = st_q.iss_prog;
    assign iss_pc     = st_q.iss_pc;
    assign iss_mask   = st_q.iss_mask;
    assign lane_valid = seq_busy;
endmodule

// File: rtl/simt_warp_sched_chk.sv
module simt_warp_sched_chk #(
    parameter int LANES   = 8,
    parameter int THREADS = 32,
    localparam int BEATS  = THREADS / LANES,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input logic               clk,
    input logic               rst,
    input logic               adm_valid,
    input logic               adm_accept,
    input logic               iss_valid,
    input logic [THREADS-1:0] iss_mask,
    input logic               lane_valid,
    input logic [BEAT_W-1:0]  lane_beat,
    input logic [LANES-1:0]   lane_en
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!iss_valid && !lane_valid));

    // R2
    accept_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        adm_accept |-> adm_valid);

    // R6
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (iss_mask != '0));

    // R9
    lane_start_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (lane_valid && lane_beat == '0));

    // R9
    lane_step_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_valid && lane_beat != BEAT_W'(BEATS - 1))
        |=> (lane_valid && lane_beat == $past(lane_beat) + 1'b1));

    // R9
    lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lane_valid |-> (lane_en == '0));

    // R10
    issue_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_valid && lane_beat != BEAT_W'(BEATS - 1)) |=> !iss_valid);
endmodule

bind simt_warp_sched simt_warp_sched_chk #(.LANES(LANES), .THREADS(WT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adm_valid  (adm_valid),
    .adm_accept (adm_accept),
    .iss_valid  (iss_valid),
    .iss_mask   (iss_mask),
    .lane_valid (lane_valid),
    .lane_beat  (lane_beat),
    .lane_en    (lane_en)
);

// File: tb/simt_warp_sched_test.sv
`timescale 1ns/100ps
module simt_warp_sched_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adm_valid = 1'b0;
    logic [4:0]  adm_warps = '0;
    logic [3:0]  adm_prog = '0;
    logic [15:0] adm_pc = '0;
    logic        adm_accept;
    logic        ret_valid = 1'b0;
    logic [4:0]  ret_warp = '0;
    logic        mask_wr = 1'b0;
    logic [4:0]  mask_warp = '0;
    logic [31:0] mask_val = '0;
    logic [31:0] warp_ready = '0;
    logic        iss_valid;
    logic [4:0]  iss_warp;
    logic [3:0]  iss_prog;
    logic [15:0] iss_pc;
    logic [31:0] iss_mask;
    logic        lane_valid;
    logic [1:0]  lane_beat;
    logic [7:0]  lane_en;

    int n_checks = 0;
    int n_errs   = 0;

    always #2.5 clk = ~clk;

    simt_warp_sched uut (
        .clk(clk), .rst(rst),
        .adm_valid(adm_valid), .adm_warps(adm_warps), .adm_prog(adm_prog),
        .adm_pc(adm_pc), .adm_accept(adm_accept),
        .ret_valid(ret_valid), .ret_warp(ret_warp),
        .mask_wr(mask_wr), .mask_warp(mask_warp), .mask_val(mask_val),
        .warp_ready(warp_ready),
        .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_prog(iss_prog),
        .iss_pc(iss_pc), .iss_mask(iss_mask),
        .lane_valid(lane_valid), .lane_beat(lane_beat), .lane_en(lane_en)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset;
        rst = 1'b1; adm_valid = 1'b0; ret_valid = 1'b0; mask_wr = 1'b0;
        warp_ready = '0;
        tick; tick;
        rst = 1'b0;
        tick;
    endtask

    task automatic admit(input int nw, input int prog, input int pc,
                         input bit exp_acc, input string req);
        adm_valid = 1'b1;
        adm_warps = 5'(nw);
        adm_prog  = 4'(prog);
        adm_pc    = 16'(pc);
        #1;
        chk(req, "adm_accept", adm_accept, exp_acc);
        tick;
        adm_valid = 1'b0;
    endtask

    task automatic retire(input int w);
        ret_valid = 1'b1;
        ret_warp  = 5'(w);
        tick;
        ret_valid = 1'b0;
    endtask

    task automatic write_mask(input int w, input logic [31:0] m);
        mask_wr   = 1'b1;
        mask_warp = 5'(w);
        mask_val  = m;
        tick;
        mask_wr = 1'b0;
    endtask

    task automatic wait_issue(output int n);
        n = 0;
        do begin
            tick;
            n++;
        end while (!iss_valid && n < 40);
    endtask

    task automatic count_issues(input int cycles, output int c);
        c = 0;
        for (int i = 0; i < cycles; i++) begin
            tick;
            if (iss_valid) c++;
        end
    endtask

    task automatic quiesce;
        warp_ready = '0;
        repeat (6) tick;
    endtask

    task automatic t_reset;
        do_reset;
        chk("R1", "iss_valid after reset", iss_valid, 0);
        chk("R1", "lane_valid after reset", lane_valid, 0);
        chk("R1", "lane_en after reset", lane_en, 0);
    endtask

    task automatic t_issue_order;
        int n;
        admit(2, 3, 100, 1'b1, "R1");
        warp_ready = 32'h1;
        wait_issue(n);
        chk("R6", "first issue delay", n, 1);
        chk("R2", "issued warp", iss_warp, 0);
        chk("R2", "issued prog", iss_prog, 3);
        chk("R2", "issued pc", iss_pc, 100);
        chk("R2", "issued mask", iss_mask, 32'hFFFF_FFFF);
        chk("R9", "beat0 lane_en", lane_en, 8'hFF);
        wait_issue(n);
        chk("R10", "lone warp spacing", n, 5);
        chk("R8", "pc increments", iss_pc, 101);
        warp_ready = 32'h3;
        wait_issue(n);
        chk("R10", "two-warp spacing", n, 4);
        chk("R7", "rotation to warp 1", iss_warp, 1);
        chk("R8", "warp 1 pc", iss_pc, 100);
        wait_issue(n);
        chk("R10", "two-warp spacing again", n, 4);
        chk("R7", "rotation wraps to warp 0", iss_warp, 0);
        chk("R8", "warp 0 third pc", iss_pc, 102);
        quiesce;
    endtask

    task automatic t_masks;
        int n;
        int c;
        write_mask(1, 32'h00F0_0F81);
        warp_ready = 32'h2;
        wait_issue(n);
        chk("R11", "masked warp issue delay", n, 1);
        chk("R11", "issued mask", iss_mask, 32'h00F0_0F81);
        chk("R9", "beat0 slice", lane_en, 8'h81);
        tick;
        chk("R9", "beat1 slice", lane_en, 8'h0F);
        chk("R9", "beat1 number", lane_beat, 1);
        tick;
        chk("R9", "beat2 slice", lane_en, 8'hF0);
        tick;
        chk("R9", "beat3 slice", lane_en, 8'h00);
        chk("R9", "beat3 valid", lane_valid, 1);
        write_mask(1, 32'h0);
        chk("R9", "lanes idle after beat3", lane_valid, 0);
        count_issues(8, c);
        chk("R11", "zero-mask warp issues", c, 0);
        warp_ready = 32'h3;
        wait_issue(n);
        chk("R11", "skip zero-mask warp", iss_warp, 0);
        wait_issue(n);
        chk("R6", "only warp 0 eligible", iss_warp, 0);
        chk("R10", "lone eligible spacing", n, 5);
        quiesce;
    endtask

    task automatic t_programs;
        int n;
        admit(1, 7, 200, 1'b1, "R12");
        warp_ready = 32'h4;
        wait_issue(n);
        chk("R12", "new block warp id", iss_warp, 2);
        chk("R12", "own program", iss_prog, 7);
        chk("R12", "own pc", iss_pc, 200);
        quiesce;
    endtask

    task automatic t_block_limit;
        int n;
        int c;
        do_reset;
        for (int b = 0; b < 8; b++) admit(1, b, 0, 1'b1, "R3");
        admit(1, 9, 0, 1'b0, "R3");
        retire(3);
        admit(1, 9, 50, 1'b1, "R5");
        warp_ready = 32'h8;
        wait_issue(n);
        chk("R5", "freed id reused", iss_warp, 3);
        chk("R5", "reused prog", iss_prog, 9);
        chk("R5", "reused pc", iss_pc, 50);
        quiesce;
        retire(5);
        warp_ready = 32'h20;
        count_issues(10, c);
        chk("R5", "retired warp issues", c, 0);
        quiesce;
    endtask

    task automatic t_thread_limit;
        int n;
        do_reset;
        admit(17, 1, 0, 1'b0, "R2");
        admit(0, 1, 0, 1'b0, "R2");
        admit(16, 1, 0, 1'b1, "R4");
        admit(9, 2, 0, 1'b0, "R4");
        admit(8, 2, 0, 1'b1, "R4");
        admit(1, 2, 0, 1'b0, "R4");
        for (int w = 16; w < 23; w++) retire(w);
        admit(8, 5, 300, 1'b0, "R4");
        retire(23);
        admit(8, 5, 300, 1'b1, "R5");
        warp_ready = 32'h0001_0000;
        wait_issue(n);
        chk("R5", "thread budget reused id", iss_warp, 16);
        chk("R5", "thread budget reused prog", iss_prog, 5);
        chk("R5", "thread budget reused pc", iss_pc, 300);
        quiesce;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        t_reset;
        t_issue_order;
        t_masks;
        t_programs;
        t_block_limit;
        t_thread_limit;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule